// File: doc/BRIEF.md
# Programmable Clock Ratio Divider

This block derives a clock-enable pulse from one parent clock at a ratio chosen by software. A 32-bit control register holds the divide value, a stop control and a change request. A second 32-bit register holds a gate control bit next to general-purpose storage bits. All logic runs on the parent clock. The output is a single-cycle enable pulse that downstream logic qualifies its registers with.

A new divide value does not take effect just because it is written. It is applied only when software writes the control register with the change-request bit set. The change is committed at the end of the current output period, so every output interval is a whole period of either the old ratio or the new one. A busy flag stays at 1 from the cycle after the request until the new ratio is in force. The stop bit and the gate bit can each halt the output. Either one takes effect only at a period boundary, so no partial period is ever produced.

Top module: `clk_ratio_div`

## Requirements
- R1: With divide field D in control bits [7:0] (address 0), the enable pulse `tick_o` is high for one parent cycle out of every D+1 while running.
- R2: D = 0 gives a pulse on every parent cycle, and the largest field value 255 gives one pulse every 256 cycles.
- R3: A control write with bit 29 set requests the new ratio. Bit 28 (busy) and bit 29 both read 1, and `busy_o` is 1, from the cycle after that write until the ratio is loaded; then all three read 0.
- R4: A control write with bit 29 clear updates the stored field, which reads back, but leaves the output period unchanged.
- R5: Across a ratio change, every interval between pulses equals either the old period or the new period, and the new period holds once busy has cleared.
- R6: Stop bit 27 set halts the pulses after the current period at most. Clearing it resumes full periods at the stored ratio.
- R7: Gate bit 5 of the gating register (address 1) at 1 halts the pulses, and at 0 lets them run.
- R8: All 32 bits of the gating register are stored and read back, so a read-modify-write of the gate bit leaves the other bits unchanged.
- R9: A change request made while halted shows busy for exactly one parent cycle.
- R10: After reset the control register reads 0, the gating register reads 0x00000020, busy is 0 and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 gating |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| tick_o | output | 1 | Divided clock-enable pulse |
| busy_o | output | 1 | Ratio change pending |

## Verification
The divider is driven with a fixed-seed random sequence of small divide values. Each value is written with a change request, and three consecutive intervals are measured afterwards. A wrong ratio, an off-by-one in the period, or a runt interval at the switch each show up as an interval that matches neither the old period nor the new one. Directed cases cover the two extreme field values, which separate pass-through from the widest count. A write without a change request separates a stored field from an applied one. Stop and gate are each toggled on a running divider, and a request made while halted exposes the length of the busy window.

// File: rtl/clk_ratio_div_pkg.sv
package clk_ratio_div_pkg;
   localparam int REG_W = 32;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_GATE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/clk_ratio_div_regs.sv
module clk_ratio_div_regs
   import clk_ratio_div_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int DIV_LSB  = 0,
   parameter int STOP_BIT = 27,
   parameter int GATE_BIT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             addr,
   input  logic [REG_W-1:0] wdata,
   output logic [DIV_W-1:0] div_o,
   output logic             stop_o,
   output logic [REG_W-1:0] gate_word_o,
   output logic             gate_o
);
   logic             ctrl_we;
   logic             gate_we;
   logic [DIV_W-1:0] div_q;
   logic             stop_q;

   assign ctrl_we = wr_en && (addr == SEL_CTRL);
   assign gate_we = wr_en && (addr == SEL_GATE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         stop_q <= 1'b0;
      end else if (ctrl_we) begin
         div_q  <= wdata[DIV_LSB +: DIV_W];
         stop_q <= wdata[STOP_BIT];
      end
   end

   // one storage bit per gating-register position; only the gate bit resets to 1
   for (genvar b = 0; b < REG_W; b++) begin : g_gbit
      localparam logic RST_VAL = (b == GATE_BIT);
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= RST_VAL;
         else if (gate_we)
            bit_q <= wdata[b];
      end
      assign gate_word_o[b] = bit_q;
   end

   assign div_o  = div_q;
   assign stop_o = stop_q;
   assign gate_o = gate_word_o[GATE_BIT];
endmodule

// File: rtl/clk_ratio_div_core.sv
module clk_ratio_div_core #(
   parameter int DIV_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_req,
   input  logic [DIV_W-1:0] div_field,
   input  logic             run_req,
   output logic             tick_o,
   output logic             busy_o,
   output logic [DIV_W-1:0] cur_div_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cur_q;
   logic             pend_q;
   logic             run_q;
   logic             at_end;
   logic             boundary;
   logic             tick_raw;

   assign at_end   = (cnt_q == cur_q);
   assign boundary = !run_q || at_end;
   assign tick_raw = run_q && at_end;

   // counter, run state and applied ratio change only at a period boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cur_q <= '0;
         run_q <= 1'b0;
      end else if (boundary) begin
         cnt_q <= '0;
         run_q <= run_req;
         if (pend_q)
            cur_q <= div_field;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (load_req)
         pend_q <= 1'b1;
      else if (boundary)
         pend_q <= 1'b0;
   end

   if (OUT_REG) begin : g_out_reg
      logic tick_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            tick_q <= 1'b0;
         else
            tick_q <= tick_raw;
      end
      assign tick_o = tick_q;
   end else begin : g_out_comb
      assign tick_o = tick_raw;
   end

   assign busy_o    = pend_q;
   assign cur_div_o = cur_q;
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
   import clk_ratio_div_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int DIV_LSB  = 0,
   parameter int STOP_BIT = 27,
   parameter int BUSY_BIT = 28,
   parameter int CE_BIT   = 29,
   parameter int GATE_BIT = 5,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        tick_o,
   output logic        busy_o
);
   localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

   if (DIV_W < 1 || DIV_MSB >= REG_W) begin : g_bad_div
      $error("divide field does not fit the control register");
   end
   if (STOP_BIT == BUSY_BIT || STOP_BIT == CE_BIT || BUSY_BIT == CE_BIT) begin : g_bad_flags
      $error("control flag positions must be distinct");
   end
   if ((STOP_BIT >= DIV_LSB && STOP_BIT <= DIV_MSB) ||
       (BUSY_BIT >= DIV_LSB && BUSY_BIT <= DIV_MSB) ||
       (CE_BIT   >= DIV_LSB && CE_BIT   <= DIV_MSB)) begin : g_bad_overlap
      $error("control flags overlap the divide field");
   end
   if (GATE_BIT < 0 || GATE_BIT >= REG_W) begin : g_bad_gate
      $error("gate bit outside the gating register");
   end

   logic [DIV_W-1:0] div_field;
   logic             stop_bit;
   logic             gate_bit;
   logic [REG_W-1:0] gate_word;
   logic [DIV_W-1:0] cur_div;
   logic             load_req;
   logic             run_req;
   logic [REG_W-1:0] ctrl_word;

   assign load_req = wr_en && (addr == SEL_CTRL) && wdata[CE_BIT];
   assign run_req  = !stop_bit && !gate_bit;

   clk_ratio_div_regs #(
      .DIV_W   (DIV_W),
      .DIV_LSB (DIV_LSB),
      .STOP_BIT(STOP_BIT),
      .GATE_BIT(GATE_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .div_o      (div_field),
      .stop_o     (stop_bit),
      .gate_word_o(gate_word),
      .gate_o     (gate_bit)
   );

   clk_ratio_div_core #(
      .DIV_W  (DIV_W),
      .OUT_REG(OUT_REG)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_req (load_req),
      .div_field(div_field),
      .run_req  (run_req),
      .tick_o   (tick_o),
      .busy_o   (busy_o),
      .cur_div_o(cur_div)
   );

   always_comb begin
      ctrl_word                    = '0;
      ctrl_word[DIV_LSB +: DIV_W]  = div_field;
      ctrl_word[STOP_BIT]          = stop_bit;
      ctrl_word[BUSY_BIT]          = busy_o;
      ctrl_word[CE_BIT]            = busy_o;
   end

   assign rdata = (addr == SEL_GATE) ? gate_word : ctrl_word;
endmodule

// File: rtl/clk_ratio_div_chk.sv
module clk_ratio_div_chk #(
   parameter int DIV_W  = 8,
   parameter int CE_BIT = 29
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             addr,
   input logic [31:0]      wdata,
   input logic             tick_o,
   input logic             busy_o,
   input logic [DIV_W-1:0] cur_div,
   input logic [31:0]      gate_word
);
   // R3
   req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[CE_BIT]) |=> busy_o);

   // R8
   gate_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr) |=> $stable(gate_word));

   // R1
   no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !busy_o && cur_div != '0) |=> !tick_o);

   // R5
   ratio_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_div) |-> $past(busy_o));
endmodule

bind clk_ratio_div clk_ratio_div_chk #(
   .DIV_W (DIV_W),
   .CE_BIT(CE_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .tick_o   (tick_o),
   .busy_o   (busy_o),
   .cur_div  (cur_div),
   .gate_word(gate_word)
);

// File: tb/clk_ratio_div_test.sv
module clk_ratio_div_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] CE_M   = 32'h2000_0000;
   localparam logic [31:0] BUSY_M = 32'h1000_0000;
   localparam logic [31:0] STOP_M = 32'h0800_0000;
   localparam logic [31:0] GATE_M = 32'h0000_0020;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        addr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_o;
   logic        busy_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_ratio_div uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_o(tick_o), .busy_o(busy_o)
   );

   function automatic int exp_period(input int d);
      return d + 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic sync_tick(output bit seen);
      seen = 0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (tick_o) begin seen = 1; break; end
      end
   endtask

   task automatic gap(output int n);
      n = 0;
      for (int i = 1; i <= 1000; i++) begin
         @(negedge clk);
         if (tick_o) begin n = i; break; end
      end
   endtask

   task automatic count_ticks(input int cycles, output int c);
      c = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tick_o) c++;
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (!busy_o) break;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] kept;
      int g, g1, g2, g3, c, a, d;
      bit seen;
      int unsigned seed;
      seed = 32'h5eed;
      void'($urandom(seed));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      rd(1'b0, v); chk(v == 32'h0, "R10 ctrl reset", v, 0);
      rd(1'b1, v); chk(v == GATE_M, "R10 gate reset", v, GATE_M);
      chk(busy_o == 1'b0, "R10 busy reset", busy_o, 0);
      count_ticks(30, c); chk(c == 0, "R10 no tick while gated", c, 0);

      // R8 full storage and read-modify-write
      wr(1'b1, 32'hA5A5_0F20);
      rd(1'b1, v); chk(v == 32'hA5A5_0F20, "R8 gate word readback", v, 32'hA5A5_0F20);
      rd(1'b1, v); wr(1'b1, v & ~GATE_M);
      rd(1'b1, v); chk(v == 32'hA5A5_0F00, "R8 rmw keeps others", v, 32'hA5A5_0F00);

      // R2 pass-through, R7 gate open
      sync_tick(seen); chk(seen, "R7 runs when gate 0", seen, 1);
      gap(g); chk(g == 1, "R2 divide 0 pass-through", g, 1);

      // R1 R3 R5 random ratios
      a = 0;
      for (int k = 0; k < 6; k++) begin
         d = int'($urandom % 24);
         wr(1'b0, CE_M | 32'(d));
         chk(busy_o == 1'b1, "R3 busy after request", busy_o, 1);
         rd(1'b0, v); chk((v & (CE_M | BUSY_M)) == (CE_M | BUSY_M), "R3 ce/busy readback", v, CE_M | BUSY_M);
         sync_tick(seen);
         gap(g1); gap(g2); gap(g3);
         chk(g1 == exp_period(a) || g1 == exp_period(d), "R5 interval 1", g1, exp_period(d));
         chk(g2 == exp_period(a) || g2 == exp_period(d), "R5 interval 2", g2, exp_period(d));
         chk(g3 == exp_period(d), "R1 new period", g3, exp_period(d));
         rd(1'b0, v); chk(v == 32'(d), "R3 ce and busy cleared", v, d);
         a = d;
      end

      // R4 field write without request
      wr(1'b0, 32'(a + 5));
      sync_tick(seen); gap(g1); gap(g2);
      chk(g1 == exp_period(a) && g2 == exp_period(a), "R4 period unchanged", g2, exp_period(a));
      rd(1'b0, v); chk(v == 32'(a + 5), "R4 field readback", v, a + 5);

      // R2 largest divide
      wr(1'b0, CE_M | 32'd255);
      sync_tick(seen); gap(g1); gap(g2); gap(g3);
      chk(g3 == 256, "R2 divide field 255", g3, 256);

      // R6 stop
      wr(1'b0, CE_M | 32'd3); wait_idle();
      wr(1'b0, STOP_M | 32'd3);
      repeat (5) @(negedge clk);
      count_ticks(40, c); chk(c == 0, "R6 stop halts", c, 0);
      rd(1'b0, v); chk(v == (STOP_M | 32'd3), "R6 stop readback", v, STOP_M | 32'd3);

      // R9 request while halted
      wr(1'b0, STOP_M | CE_M | 32'd6);
      chk(busy_o == 1'b1, "R9 busy first cycle", busy_o, 1);
      @(negedge clk);
      chk(busy_o == 1'b0, "R9 busy one cycle only", busy_o, 0);

      // R6 resume
      wr(1'b0, 32'd6);
      sync_tick(seen); gap(g); chk(g == 7, "R6 resume full period", g, 7);

      // R7 gate halts, R8 other bits kept
      rd(1'b1, kept); wr(1'b1, kept | GATE_M);
      repeat (10) @(negedge clk);
      count_ticks(40, c); chk(c == 0, "R7 gate halts", c, 0);
      rd(1'b1, v); chk(v == 32'hA5A5_0F20, "R8 gate set keeps others", v, 32'hA5A5_0F20);
      wr(1'b1, v & ~GATE_M);
      sync_tick(seen); gap(g); chk(g == 7, "R7 gate reopened", g, 7);

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule